// File: doc/BRIEF.md
# Receive Channel Selection Gate

This block sits behind a framed, time-division serial receiver. The receiver signals each fully assembled word with a one-cycle strobe. The gate tracks which channel of the current frame that word belongs to and decides whether it goes to the consumer. A delivered word lands in the output data register and sets a ready flag. It also raises a one-cycle DMA request and, in the interrupt-on-ready mode, a one-cycle interrupt. A dropped word leaves every output untouched.

Channels are grouped into 16-channel blocks: block k covers channels 16k to 16k+15. In all-channels mode every channel below the programmed frame length is delivered. In selective mode a per-channel enable bit decides. The enable bits come from eight 16-bit maps, packed side by side into one bus. Map k occupies bits 16k to 16k+15, and bit n of a map stands for channel n mod 16 of the block it serves.

The configuration is taken in when a frame-sync pulse arrives and stays fixed for the rest of the frame. It covers the mode bit, the partition choice, the interrupt mode, the frame length and the maps.

Top module: `rx_slot_gate`

## Requirements
- R1: With selMode=0, every word whose channel is below frameLen is delivered, whatever the maps hold.
- R2: With selMode=1 and eightPart=1, a word in channel c is delivered only if bit (c mod 16) of map (c div 16) is set. Map k is enMap[16k+15:16k].
- R3: With selMode=1 and eightPart=0, blocks 0, 2, 4 and 6 use map 0, and blocks 1, 3, 5 and 7 use map 1. The bit used is channel mod 16, and maps 2 to 7 are ignored.
- R4: A delivered word appears on dataOut in the cycle after its strobe. In that same cycle rdyFlag is 1 and dmaReq is high for exactly that one cycle.
- R5: A dropped word leaves dataOut unchanged. It does not set rdyFlag and raises neither dmaReq nor irqOut.
- R6: irqOut pulses together with dmaReq only when irqMode is 2'b00. Any other irqMode value gives no interrupt.
- R7: A frameSync pulse restarts the channel count at 0. A word strobed in the same cycle as frameSync is channel 0, and each later strobe advances the count by one.
- R8: Words in a channel at or beyond frameLen are ignored until the next frameSync. So are words that arrive after reset but before the first frameSync.
- R9: The mode, partition choice, interrupt mode, frame length and maps are sampled at frameSync. Changing them mid-frame has no effect on the current frame.
- R10: rdyFlag stays 1 until readAck is high. If readAck and a delivered word arrive in the same cycle, rdyFlag ends up 1.
- R11: After reset, dataOut, rdyFlag, dmaReq and irqOut are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameSync | input | 1 | One-cycle pulse that starts a frame |
| wordValid | input | 1 | One-cycle strobe: an assembled word is ready |
| wordIn | input | WORD_W | Assembled receive word |
| frameLen | input | CNT_W | Channels per frame (1 to MAX_CH) |
| selMode | input | 1 | 0: all channels, 1: selective |
| eightPart | input | 1 | 0: two-map assignment, 1: eight-map assignment |
| irqMode | input | 2 | Interrupt source select; 2'b00 = on ready |
| enMap | input | MAX_CH | Eight 16-bit enable maps, map k at bits 16k+15:16k |
| readAck | input | 1 | Consumer has taken the data; clears rdyFlag |
| dataOut | output | WORD_W | Last delivered word |
| rdyFlag | output | 1 | Unread delivered word present |
| dmaReq | output | 1 | One-cycle DMA request per delivered word |
| irqOut | output | 1 | One-cycle interrupt per delivered word in on-ready mode |

## Verification
Some behaviours are checked on every cycle. A DMA request always comes with a raised ready flag and with the word strobed one cycle earlier, and it never appears without a strobe. An interrupt never appears without a DMA request. The ready flag never falls unless readAck was high. A frame start in all-channels mode always delivers the word strobed with it. Other behaviours need the bench's frames, where a reference model predicts the delivery pattern: which map and bit each channel uses in each partition mode, where the frame length cuts off, and that configuration changes made mid-frame are ignored.

// File: rtl/rx_slot_pkg.sv
package rx_slot_pkg;

  // Interrupt source encoding that ties the interrupt to the ready flag
  localparam logic [1:0] IRQ_ON_READY = 2'b00;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;    // deliver the current word
    logic irqEn;   // raise an interrupt with this delivery
    logic ack;     // consumer read acknowledge
  } gateStrb_t;

endpackage

// File: rtl/rx_slot_ctrl.sv
module rx_slot_ctrl
  import rx_slot_pkg::*;
#(
  parameter int MAX_CH = 128,
  parameter int BLK_CH = 16,
  localparam int CNT_W = $clog2(MAX_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              wordValid,
  input  logic [CNT_W-1:0]  frameLen,
  input  logic              selMode,
  input  logic              eightPart,
  input  logic [1:0]        irqMode,
  input  logic [MAX_CH-1:0] enMap,
  input  logic              readAck,
  output gateStrb_t         strb
);

  localparam int NUM_BLK = MAX_CH / BLK_CH;
  localparam int BLK_W   = $clog2(BLK_CH);
  localparam int IDX_W   = $clog2(NUM_BLK);
  localparam int CH_W    = $clog2(MAX_CH);

  // Frame-local state
  logic [CNT_W-1:0]  chanCnt;
  logic              inFrame;

  // Configuration captured at frame sync
  logic              cfgSel;
  logic              cfgEight;
  logic [1:0]        cfgIrq;
  logic [CNT_W-1:0]  cfgLen;
  logic [MAX_CH-1:0] cfgMap;

  // Effective values for the current cycle
  logic              curSel;
  logic              curEight;
  logic [1:0]        curIrq;
  logic [CNT_W-1:0]  curLen;
  logic [MAX_CH-1:0] curMap;
  logic [CNT_W-1:0]  curCh;
  logic              active;
  logic              inRange;
  logic [IDX_W-1:0]  blkIdx;
  logic [IDX_W-1:0]  mapIdx;
  logic [BLK_W-1:0]  slotIdx;
  logic              hit;
  logic [BLK_CH-1:0] mapRow [NUM_BLK];

  // A sync in this cycle makes the new configuration apply to a word in the same cycle
  always_comb begin
    curSel   = frameSync ? selMode   : cfgSel;
    curEight = frameSync ? eightPart : cfgEight;
    curIrq   = frameSync ? irqMode   : cfgIrq;
    curLen   = frameSync ? frameLen  : cfgLen;
    curMap   = frameSync ? enMap     : cfgMap;
    curCh    = frameSync ? '0        : chanCnt;
    active   = frameSync | inFrame;
  end

  // Split the map bus into one row per block
  for (genvar k = 0; k < NUM_BLK; k++) begin : gMapRow
    assign mapRow[k] = curMap[k*BLK_CH +: BLK_CH];
  end

  always_comb begin
    blkIdx  = curCh[CH_W-1:BLK_W];
    slotIdx = curCh[BLK_W-1:0];
    mapIdx  = curEight ? blkIdx : IDX_W'(blkIdx[0]);
    hit     = mapRow[mapIdx][slotIdx];
    inRange = (curCh < curLen) && (curCh < CNT_W'(MAX_CH));
  end

  always_comb begin
    strb.take  = wordValid && active && inRange && (!curSel || hit);
    strb.irqEn = (curIrq == IRQ_ON_READY);
    strb.ack   = readAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanCnt  <= '0;
      inFrame  <= 1'b0;
      cfgSel   <= 1'b0;
      cfgEight <= 1'b0;
      cfgIrq   <= 2'b00;
      cfgLen   <= '0;
      cfgMap   <= '0;
    end else if (frameSync) begin
      inFrame  <= 1'b1;
      chanCnt  <= wordValid ? CNT_W'(1) : '0;
      cfgSel   <= selMode;
      cfgEight <= eightPart;
      cfgIrq   <= irqMode;
      cfgLen   <= frameLen;
      cfgMap   <= enMap;
    end else if (wordValid && inFrame && (chanCnt < CNT_W'(MAX_CH))) begin
      chanCnt <= chanCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rx_slot_dp.sv
module rx_slot_dp
  import rx_slot_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrb_t         strb,
  input  logic [WORD_W-1:0] wordIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              rdyFlag,
  output logic              dmaReq,
  output logic              irqOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      rdyFlag <= 1'b0;
      dmaReq  <= 1'b0;
      irqOut  <= 1'b0;
    end else begin
      if (strb.take) dataOut <= wordIn;
      if (strb.take)     rdyFlag <= 1'b1;
      else if (strb.ack) rdyFlag <= 1'b0;
      dmaReq <= strb.take;
      irqOut <= strb.take && strb.irqEn;
    end
  end

endmodule

// File: rtl/rx_slot_gate.sv
module rx_slot_gate
  import rx_slot_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int MAX_CH = 128,
  parameter int BLK_CH = 16,
  localparam int CNT_W = $clog2(MAX_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [CNT_W-1:0]  frameLen,
  input  logic              selMode,
  input  logic              eightPart,
  input  logic [1:0]        irqMode,
  input  logic [MAX_CH-1:0] enMap,
  input  logic              readAck,
  output logic [WORD_W-1:0] dataOut,
  output logic              rdyFlag,
  output logic              dmaReq,
  output logic              irqOut
);

  gateStrb_t strb;

  rx_slot_ctrl #(.MAX_CH(MAX_CH), .BLK_CH(BLK_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .wordValid(wordValid),
    .frameLen(frameLen), .selMode(selMode), .eightPart(eightPart),
    .irqMode(irqMode), .enMap(enMap), .readAck(readAck), .strb(strb)
  );

  rx_slot_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIn(wordIn),
    .dataOut(dataOut), .rdyFlag(rdyFlag), .dmaReq(dmaReq), .irqOut(irqOut)
  );

endmodule

// File: rtl/rx_slot_gate_chk.sv
module rx_slot_gate_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameSync,
  input logic              wordValid,
  input logic [WORD_W-1:0] wordIn,
  input logic [CNT_W-1:0]  frameLen,
  input logic              selMode,
  input logic              readAck,
  input logic [WORD_W-1:0] dataOut,
  input logic              rdyFlag,
  input logic              dmaReq,
  input logic              irqOut
);

  // R4: a request carries the word strobed one cycle before and a raised ready flag
  a_r4_deliver_data: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (rdyFlag && dataOut == $past(wordIn)));

  // R5: no request without a strobe in the previous cycle
  a_r5_no_spurious_req: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wordValid) |-> !dmaReq);

  // R6: an interrupt is always accompanied by a request
  a_r6_irq_with_req: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> dmaReq);

  // R10: ready drops only after an acknowledge
  a_r10_ready_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdyFlag && !readAck) |=> rdyFlag);

  // R1 and R7: a word strobed with the frame start in all-channels mode is delivered
  a_r1_sync_word_taken: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && wordValid && !selMode && frameLen != '0) |=> dmaReq);

endmodule

bind rx_slot_gate rx_slot_gate_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameSync(frameSync), .wordValid(wordValid),
  .wordIn(wordIn), .frameLen(frameLen), .selMode(selMode), .readAck(readAck),
  .dataOut(dataOut), .rdyFlag(rdyFlag), .dmaReq(dmaReq), .irqOut(irqOut)
);

// File: tb/rx_slot_gate_tb.sv
module rx_slot_gate_tb;

  localparam int WORD_W = 16;
  localparam int MAX_CH = 128;
  localparam int CNT_W  = 8;

  typedef struct packed {
    logic         sel;
    logic         eight;
    logic [1:0]   irqm;
    logic [7:0]   len;
    logic [7:0]   nWords;
    logic [127:0] maps;
  } row_t;

  // Frame scenarios; map k sits at bits 16k+15:16k
  localparam row_t ROWS [5] = '{
    '{1'b0, 1'b1, 2'b00, 8'd128, 8'd128, 128'h0},                                          // R1 all channels
    '{1'b1, 1'b1, 2'b00, 8'd40,  8'd44,  128'h0000_0000_0000_0000_0000_0080_0000_8001},  // R2 R8 channels 0,15,39
    '{1'b1, 1'b0, 2'b00, 8'd64,  8'd64,  128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_0F00_00F0},  // R3 two maps
    '{1'b1, 1'b1, 2'b10, 8'd128, 8'd128, 128'h1234_8001_F00F_0000_FFFF_A5A5_5A5A_0001},  // R2 R6 mixed
    '{1'b0, 1'b0, 2'b01, 8'd20,  8'd24,  128'h0}                                           // R6 R8 short frame
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              frameSync = 1'b0;
  logic              wordValid = 1'b0;
  logic [WORD_W-1:0] wordIn = '0;
  logic [CNT_W-1:0]  frameLen = '0;
  logic              selMode = 1'b0;
  logic              eightPart = 1'b0;
  logic [1:0]        irqMode = 2'b00;
  logic [MAX_CH-1:0] enMap = '0;
  logic              readAck = 1'b0;
  logic [WORD_W-1:0] dataOut;
  logic              rdyFlag;
  logic              dmaReq;
  logic              irqOut;

  int errors = 0;
  int checks = 0;
  logic [WORD_W-1:0] lastData = '0;

  always #4 clk = ~clk;

  rx_slot_gate #(.WORD_W(WORD_W), .MAX_CH(MAX_CH), .BLK_CH(16)) u_dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .wordValid(wordValid),
    .wordIn(wordIn), .frameLen(frameLen), .selMode(selMode), .eightPart(eightPart),
    .irqMode(irqMode), .enMap(enMap), .readAck(readAck),
    .dataOut(dataOut), .rdyFlag(rdyFlag), .dmaReq(dmaReq), .irqOut(irqOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expDel(row_t r, int ch);
    int m;
    if (ch >= int'(r.len)) return 1'b0;
    if (!r.sel) return 1'b1;
    m = r.eight ? ch / 16 : (ch / 16) % 2;
    return r.maps[m*16 + ch%16];
  endfunction

  task automatic setCfg(input logic s, input logic e, input logic [1:0] im,
                        input logic [7:0] len, input logic [127:0] maps);
    selMode = s; eightPart = e; irqMode = im; frameLen = len; enMap = maps;
  endtask

  task automatic syncOnly();
    @(negedge clk); frameSync = 1'b1;
    @(negedge clk); frameSync = 1'b0;
  endtask

  // Strobe one word (optionally with frameSync), then check the outputs after the edge
  task automatic sendWord(input logic [WORD_W-1:0] w, input logic expD, input logic irqOn,
                          input logic ack, input logic withSync, input string req);
    logic expRdy;
    @(negedge clk);
    wordValid = 1'b1; wordIn = w; readAck = ack; frameSync = withSync;
    expRdy = expD ? 1'b1 : (ack ? 1'b0 : rdyFlag);
    @(negedge clk);
    wordValid = 1'b0; readAck = 1'b0; frameSync = 1'b0;
    if (expD) lastData = w;
    chk(dmaReq == expD, {req, " dmaReq"}, 32'(dmaReq), 32'(expD));
    chk(rdyFlag == expRdy, {req, " rdyFlag"}, 32'(rdyFlag), 32'(expRdy));
    chk(dataOut == lastData, {req, " dataOut"}, 32'(dataOut), 32'(lastData));
    chk(irqOut == (expD && irqOn), {req, " irqOut"}, 32'(irqOut), 32'(expD && irqOn));
  endtask

  initial begin : watchdog
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(dataOut == '0 && !rdyFlag && !dmaReq && !irqOut, "R11 reset outputs",
        {dataOut, 13'b0, rdyFlag, dmaReq, irqOut}, 32'h0);
    rstN = 1'b1;
    // R8: no frame started yet, all-channels config still drops the word
    setCfg(1'b0, 1'b1, 2'b00, 8'd128, '0);
    sendWord(16'hBEEF, 1'b0, 1'b1, 1'b0, 1'b0, "R8 before first sync");

    // Table-driven frames
    for (int r = 0; r < 5; r++) begin
      setCfg(ROWS[r].sel, ROWS[r].eight, ROWS[r].irqm, ROWS[r].len, ROWS[r].maps);
      syncOnly();
      for (int c = 0; c < int'(ROWS[r].nWords); c++) begin
        sendWord(16'((r << 8) | c), expDel(ROWS[r], c), ROWS[r].irqm == 2'b00, 1'b1, 1'b0,
                 $sformatf("R2 R3 R1 R8 row%0d ch%0d", r, c));
      end
    end

    // R10: ready holds without acknowledge, clears on acknowledge, delivery beats ack
    setCfg(1'b0, 1'b1, 2'b00, 8'd128, '0);
    syncOnly();
    sendWord(16'h1111, 1'b1, 1'b1, 1'b0, 1'b0, "R10 deliver no ack");
    repeat (3) @(negedge clk);
    chk(rdyFlag == 1'b1, "R10 ready held", 32'(rdyFlag), 32'h1);
    readAck = 1'b1; @(negedge clk); readAck = 1'b0;
    chk(rdyFlag == 1'b0, "R10 ready cleared", 32'(rdyFlag), 32'h0);
    sendWord(16'h2222, 1'b1, 1'b1, 1'b1, 1'b0, "R10 ack with delivery");

    // R9: mid-frame configuration change ignored until next sync
    setCfg(1'b1, 1'b1, 2'b00, 8'd128, '0);
    syncOnly();
    setCfg(1'b0, 1'b1, 2'b00, 8'd128, '1);
    sendWord(16'h3333, 1'b0, 1'b1, 1'b1, 1'b0, "R9 mid-frame change ch0");
    sendWord(16'h3334, 1'b0, 1'b1, 1'b1, 1'b0, "R9 mid-frame change ch1");
    syncOnly();
    sendWord(16'h3335, 1'b1, 1'b1, 1'b1, 1'b0, "R9 after new sync");

    // R7: only channel 0 enabled; a word strobed with sync is channel 0
    setCfg(1'b1, 1'b1, 2'b00, 8'd128, 128'h1);
    syncOnly();
    sendWord(16'h4440, 1'b1, 1'b1, 1'b1, 1'b0, "R7 ch0");
    sendWord(16'h4441, 1'b0, 1'b1, 1'b1, 1'b0, "R7 ch1");
    sendWord(16'h4442, 1'b1, 1'b1, 1'b1, 1'b1, "R7 word with sync is ch0");
    sendWord(16'h4443, 1'b0, 1'b1, 1'b1, 1'b0, "R7 next is ch1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule